// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits between a host's parallel flash bus and the embedded-algorithm sequencer of a NOR flash array. It works in the core clock domain. It oversamples the select, write and read strobes, then forms one bus write cycle from each pulse of the write strobe. The address is captured when the strobe becomes active. The data is captured when the strobe is released.

A multi-cycle unlock prefix guards every command except the single-cycle suspend, resume and abort codes. Each recognised command goes to the sequencer as a one-clock request pulse. The pulse carries the address and data of the cycle that completed the command.

The sequencer reports what it is doing through three level inputs. The decoder uses them to limit which commands it accepts:
- While a program runs, the decoder accepts nothing.
- While an erase runs, it accepts only the suspend code.
- While an erase is suspended, it accepts resume and program but refuses both erase commands.

A separate synchronous level input forces the decoder back to its idle read state.

Top module: `nfd_cmd_decoder`

## Requirements
- R1: After `rst_n` is released, all request outputs are low. No request is issued while the bus is quiet.
- R2: A bus write cycle exists only while `bus_sel_n`=0, `bus_wr_n`=0 and `bus_rd_n`=1. The address is taken when that condition begins and the data when it ends. Both must be held for at least 3 clocks around each transition. A strobe pulse with `bus_rd_n`=0 is no cycle at all and leaves the sequence state untouched.
- R3: The cycles (555h/AAh), (2AAh/55h), (555h/A0h), (A/D) issue one `req_program` pulse with `req_addr`=A and `req_data`=D. Addresses are compared on bits [10:0] and codes on data bits [7:0].
- R4: Two unlock pairs around (555h/80h), followed by (SA/30h), issue one `req_sector_erase` pulse with `req_addr`=SA.
- R5: The same erase prefix followed by (555h/10h) issues one `req_chip_erase` pulse.
- R6: A cycle that does not match the expected unlock or command cycle returns the decoder to idle without a request. A complete sequence written afterwards is accepted.
- R7: Code F0h in any sequence position except the program data slot issues `req_reset` and returns to idle. In the data slot, F0h is programmed as data.
- R8: While `alg_prog_busy`=1, every write is ignored: no request is issued, and no partial sequence survives the end of the busy period.
- R9: While `alg_erase_busy`=1 (and not program busy), only code B0h is honoured, and it issues `req_suspend`. All other writes are ignored.
- R10: While `alg_erase_held`=1 (and neither busy input is set), code 30h alone issues `req_resume`, a program sequence is accepted, and both erase sequences are refused. Outside this mode, code 30h alone does nothing.
- R11: While `dev_rst_n`=0, the decoder is held idle and issues no requests. A partial sequence is lost.
- R12: Each request is exactly one clock wide, and at most one request output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_rst_n | input | 1 | Synchronous active-low device reset, returns decoder to read mode |
| bus_sel_n | input | 1 | Host chip select, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_addr | input | ADDR_W | Host address bus |
| bus_data | input | DATA_W | Host data bus |
| alg_prog_busy | input | 1 | Sequencer is running a program |
| alg_erase_busy | input | 1 | Sequencer is running an erase |
| alg_erase_held | input | 1 | Sequencer has an erase suspended |
| req_program | output | 1 | One-clock program request |
| req_sector_erase | output | 1 | One-clock sector erase request |
| req_chip_erase | output | 1 | One-clock chip erase request |
| req_suspend | output | 1 | One-clock erase suspend request |
| req_resume | output | 1 | One-clock erase resume request |
| req_reset | output | 1 | One-clock return-to-read request |
| req_addr | output | ADDR_W | Address of the cycle that completed the last request |
| req_data | output | DATA_W | Data of the cycle that completed the last request |

## Verification
The assertions check the following on every cycle:
- Requests stay one-hot and one clock wide.
- Two completed bus cycles are never on adjacent clocks.
- A program request always follows the data-slot state.
- The program-busy, erase-busy, erase-held and device-reset modes hold back the requests they forbid one clock later.

Only the directed scenarios can show the positive side: that each command code and unlock order actually produces its request with the right address and data. They also show that a wrong cycle, an abort, or a busy period really discards a half-written sequence, and that address and data come from the correct strobe edges.

// File: rtl/nfd_pkg.sv
package nfd_pkg;
  localparam int UNLK_W = 11;

  localparam logic [UNLK_W-1:0] K_ADDR_A = 11'h555;
  localparam logic [UNLK_W-1:0] K_ADDR_B = 11'h2AA;

  localparam logic [7:0] K_UNLK_A = 8'hAA;
  localparam logic [7:0] K_UNLK_B = 8'h55;
  localparam logic [7:0] K_PGM    = 8'hA0;
  localparam logic [7:0] K_ERS    = 8'h80;
  localparam logic [7:0] K_SECT   = 8'h30;
  localparam logic [7:0] K_CHIP   = 8'h10;
  localparam logic [7:0] K_ABORT  = 8'hF0;
  localparam logic [7:0] K_HOLD   = 8'hB0;
  localparam logic [7:0] K_CONT   = 8'h30;

  typedef enum logic [1:0] {
    MD_READ,
    MD_PROG,
    MD_ERASE,
    MD_HELD
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_UA,
    S_UB,
    S_PDATA,
    S_EX,
    S_EA,
    S_EB
  } seq_e;

  typedef struct packed {
    logic prog;
    logic sect;
    logic chip;
    logic hold;
    logic cont;
    logic abort;
  } req_t;
endpackage

// File: rtl/nfd_bus_capture.sv
module nfd_bus_capture #(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bus_sel_n,
  input  logic              bus_wr_n,
  input  logic              bus_rd_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              cyc_valid,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [DATA_W-1:0] cyc_data
);
  localparam int PIPE_N = SYNC_N + 1;

  logic              strobe_raw;
  logic [PIPE_N-1:0] st_q, st_d;
  logic              st_now, st_old, fall, rise;
  logic [ADDR_W-1:0] a_lat_q;
  logic              valid_d;

  assign strobe_raw = ~bus_sel_n & ~bus_wr_n & bus_rd_n;

  always_comb begin
    st_d = clr ? '0 : {st_q[PIPE_N-2:0], strobe_raw};
  end

  assign st_now  = st_q[PIPE_N-2];
  assign st_old  = st_q[PIPE_N-1];
  assign fall    = st_now & ~st_old;
  assign rise    = ~st_now & st_old;
  assign valid_d = rise & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= '0;
      cyc_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      cyc_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_lat_q <= '0;
    end else if (fall) begin
      a_lat_q <= bus_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_addr <= '0;
      cyc_data <= '0;
    end else if (rise) begin
      cyc_addr <= a_lat_q;
      cyc_data <= bus_data;
    end
  end

  a_r2_valid_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);
endmodule

// File: rtl/nfd_mode_gate.sv
module nfd_mode_gate
  import nfd_pkg::*;
(
  input  logic       prog_busy,
  input  logic       erase_busy,
  input  logic       erase_held,
  input  logic       cyc_valid,
  input  logic [7:0] cyc_code,
  output mode_e      mode,
  output logic       fsm_cyc,
  output logic       hold_hit
);
  always_comb begin
    if (prog_busy)       mode = MD_PROG;
    else if (erase_busy) mode = MD_ERASE;
    else if (erase_held) mode = MD_HELD;
    else                 mode = MD_READ;
  end

  always_comb begin
    fsm_cyc  = 1'b0;
    hold_hit = 1'b0;
    unique case (mode)
      MD_READ, MD_HELD: fsm_cyc  = cyc_valid;
      MD_ERASE:         hold_hit = cyc_valid & (cyc_code == K_HOLD);
      default:          ;
    endcase
  end
endmodule

// File: rtl/nfd_cmd_fsm.sv
module nfd_cmd_fsm
  import nfd_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  mode_e             mode,
  input  logic              fsm_cyc,
  input  logic              hold_hit,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_data,
  output req_t              req_q,
  output logic [ADDR_W-1:0] req_addr_q,
  output logic [DATA_W-1:0] req_data_q
);
  seq_e       st_q, st_d;
  req_t       req_d;
  logic       ld_en;
  logic [7:0] code;
  logic       at_a, at_b, held;

  assign code = cyc_data[7:0];
  assign at_a = (cyc_addr[UNLK_W-1:0] == K_ADDR_A);
  assign at_b = (cyc_addr[UNLK_W-1:0] == K_ADDR_B);
  assign held = (mode == MD_HELD);

  always_comb begin
    st_d  = st_q;
    req_d = '0;
    if (clr) begin
      st_d = S_IDLE;
    end else if (mode == MD_PROG || mode == MD_ERASE) begin
      st_d       = S_IDLE;
      req_d.hold = hold_hit;
    end else if (fsm_cyc) begin
      if (st_q != S_PDATA && code == K_ABORT) begin
        req_d.abort = 1'b1;
        st_d        = S_IDLE;
      end else begin
        unique case (st_q)
          S_IDLE: begin
            if (at_a && code == K_UNLK_A)   st_d = S_UA;
            else if (held && code == K_CONT) req_d.cont = 1'b1;
          end
          S_UA: st_d = (at_b && code == K_UNLK_B) ? S_UB : S_IDLE;
          S_UB: begin
            if (at_a && code == K_PGM)                st_d = S_PDATA;
            else if (at_a && code == K_ERS && !held)  st_d = S_EX;
            else                                      st_d = S_IDLE;
          end
          S_PDATA: begin
            req_d.prog = 1'b1;
            st_d       = S_IDLE;
          end
          S_EX: st_d = (at_a && code == K_UNLK_A) ? S_EA : S_IDLE;
          S_EA: st_d = (at_b && code == K_UNLK_B) ? S_EB : S_IDLE;
          S_EB: begin
            if (code == K_SECT && !held)              req_d.sect = 1'b1;
            else if (at_a && code == K_CHIP && !held) req_d.chip = 1'b1;
            st_d = S_IDLE;
          end
          default: st_d = S_IDLE;
        endcase
      end
    end
  end

  assign ld_en = |req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      req_q <= '0;
    end else begin
      st_q  <= st_d;
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr_q <= '0;
      req_data_q <= '0;
    end else if (ld_en) begin
      req_addr_q <= cyc_addr;
      req_data_q <= cyc_data;
    end
  end

  a_r3_prog_from_slot: assert property (@(posedge clk) disable iff (!rst_n)
    req_q.prog |-> $past(st_q) == S_PDATA);
  a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_q));
  a_r12_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_q) |=> !(|req_q));
  a_r8_prog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PROG) |=> req_q == '0);
  a_r9_erase_hold_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_ERASE) |=> !(req_q.prog || req_q.sect || req_q.chip || req_q.cont || req_q.abort));
  a_r10_held_no_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_HELD) |=> !(req_q.sect || req_q.chip));
  a_r11_clr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (req_q == '0) && (st_q == S_IDLE));
endmodule

// File: rtl/nfd_cmd_decoder.sv
module nfd_cmd_decoder
  import nfd_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_wr_n,
  input  logic              bus_rd_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              alg_prog_busy,
  input  logic              alg_erase_busy,
  input  logic              alg_erase_held,
  output logic              req_program,
  output logic              req_sector_erase,
  output logic              req_chip_erase,
  output logic              req_suspend,
  output logic              req_resume,
  output logic              req_reset,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              clr;
  logic              cyc_valid;
  logic [ADDR_W-1:0] cyc_addr;
  logic [DATA_W-1:0] cyc_data;
  mode_e             mode;
  logic              fsm_cyc, hold_hit;
  req_t              req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];
  assign clr       = ~dev_rst_n;

  nfd_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_N(2)) u_cap (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (clr),
    .bus_sel_n (bus_sel_n),
    .bus_wr_n  (bus_wr_n),
    .bus_rd_n  (bus_rd_n),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .cyc_valid (cyc_valid),
    .cyc_addr  (cyc_addr),
    .cyc_data  (cyc_data)
  );

  nfd_mode_gate u_gate (
    .prog_busy  (alg_prog_busy),
    .erase_busy (alg_erase_busy),
    .erase_held (alg_erase_held),
    .cyc_valid  (cyc_valid),
    .cyc_code   (cyc_data[7:0]),
    .mode       (mode),
    .fsm_cyc    (fsm_cyc),
    .hold_hit   (hold_hit)
  );

  nfd_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (clr),
    .mode       (mode),
    .fsm_cyc    (fsm_cyc),
    .hold_hit   (hold_hit),
    .cyc_addr   (cyc_addr),
    .cyc_data   (cyc_data),
    .req_q      (req_q),
    .req_addr_q (req_addr),
    .req_data_q (req_data)
  );

  assign req_program      = req_q.prog;
  assign req_sector_erase = req_q.sect;
  assign req_chip_erase   = req_q.chip;
  assign req_suspend      = req_q.hold;
  assign req_resume       = req_q.cont;
  assign req_reset        = req_q.abort;

  a_r11_dev_reset_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dev_rst_n |=> !(req_program || req_sector_erase || req_chip_erase ||
                     req_suspend || req_resume || req_reset));
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> !(req_program || req_sector_erase || req_chip_erase ||
                     req_suspend || req_resume || req_reset));
endmodule

// File: tb/test_nfd_cmd_decoder.sv
`timescale 1ns/1ps
module test_nfd_cmd_decoder;
  localparam int AW = 23;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n, dev_rst_n, sel_n, wr_n, rd_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic p_busy, e_busy, e_held;
  logic r_prog, r_sect, r_chip, r_hold, r_cont, r_abort;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_data;

  always #2 clk = ~clk;

  nfd_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) i_nfd_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n),
    .bus_sel_n(sel_n), .bus_wr_n(wr_n), .bus_rd_n(rd_n),
    .bus_addr(addr), .bus_data(data),
    .alg_prog_busy(p_busy), .alg_erase_busy(e_busy), .alg_erase_held(e_held),
    .req_program(r_prog), .req_sector_erase(r_sect), .req_chip_erase(r_chip),
    .req_suspend(r_hold), .req_resume(r_cont), .req_reset(r_abort),
    .req_addr(r_addr), .req_data(r_data)
  );

  int total = 0, bad = 0;
  int n_prog = 0, n_sect = 0, n_chip = 0, n_hold = 0, n_cont = 0, n_abort = 0;
  int n_wide = 0, n_multi = 0;
  int b_prog, b_sect, b_chip, b_hold, b_cont, b_abort;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;
  logic prev_any = 1'b0;

  always @(negedge clk) begin
    int cnt;
    cnt = r_prog + r_sect + r_chip + r_hold + r_cont + r_abort;
    if (cnt > 1) n_multi++;
    if (cnt > 0 && prev_any) n_wide++;
    prev_any = (cnt > 0);
    if (r_prog)  n_prog++;
    if (r_sect)  n_sect++;
    if (r_chip)  n_chip++;
    if (r_hold)  n_hold++;
    if (r_cont)  n_cont++;
    if (r_abort) n_abort++;
    if (cnt > 0) begin
      last_addr = r_addr;
      last_data = r_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic snap();
    b_prog = n_prog; b_sect = n_sect; b_chip = n_chip;
    b_hold = n_hold; b_cont = n_cont; b_abort = n_abort;
  endtask

  task automatic chk_counts(input string tag, input int pr, input int se, input int ch,
                            input int ho, input int co, input int ab);
    chk(n_prog - b_prog == pr, {tag, " program count"}, n_prog - b_prog, pr);
    chk(n_sect - b_sect == se, {tag, " sector count"}, n_sect - b_sect, se);
    chk(n_chip - b_chip == ch, {tag, " chip count"}, n_chip - b_chip, ch);
    chk(n_hold - b_hold == ho, {tag, " suspend count"}, n_hold - b_hold, ho);
    chk(n_cont - b_cont == co, {tag, " resume count"}, n_cont - b_cont, co);
    chk(n_abort - b_abort == ab, {tag, " reset count"}, n_abort - b_abort, ab);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; data = d; rd_n = 1'b1; sel_n = 1'b0; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic unlock();
    wr(23'h555, 16'h00AA);
    wr(23'h2AA, 16'h0055);
  endtask

  task automatic t_reset();
    snap();
    settle();
    chk(!(r_prog | r_sect | r_chip | r_hold | r_cont | r_abort), "R1 outputs after reset",
        {r_prog, r_sect, r_chip, r_hold, r_cont, r_abort}, 0);
    chk_counts("R1", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_program();
    snap();
    unlock(); wr(23'h555, 16'h00A0); wr(23'h123456, 16'hBEEF);
    settle();
    chk_counts("R3", 1, 0, 0, 0, 0, 0);
    chk(last_addr == 23'h123456, "R3 program address", last_addr, 23'h123456);
    chk(last_data == 16'hBEEF, "R3 program data", last_data, 16'hBEEF);
  endtask

  task automatic t_capture();
    snap();
    unlock(); wr(23'h555, 16'h00A0);
    @(negedge clk);
    addr = 23'h0ABCDE; data = 16'h1111; rd_n = 1'b1; sel_n = 1'b0; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    addr = 23'h7FFFFF; data = 16'h2222;
    repeat (3) @(negedge clk);
    data = 16'h3C3C;
    repeat (4) @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1;
    repeat (5) @(negedge clk);
    settle();
    chk(last_addr == 23'h0ABCDE, "R2 address at strobe start", last_addr, 23'h0ABCDE);
    chk(last_data == 16'h3C3C, "R2 data at strobe end", last_data, 16'h3C3C);
    snap();
    wr(23'h555, 16'h00AA);
    @(negedge clk);
    addr = 23'h2AA; data = 16'h0077; rd_n = 1'b0; sel_n = 1'b0; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    repeat (5) @(negedge clk);
    wr(23'h2AA, 16'h0055); wr(23'h555, 16'h00A0); wr(23'h000042, 16'h5A5A);
    settle();
    chk_counts("R2 read-low pulse ignored", 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_sector();
    snap();
    unlock(); wr(23'h555, 16'h0080); unlock(); wr(23'h7F0000, 16'h0030);
    settle();
    chk_counts("R4", 0, 1, 0, 0, 0, 0);
    chk(last_addr == 23'h7F0000, "R4 sector address", last_addr, 23'h7F0000);
  endtask

  task automatic t_chip();
    snap();
    unlock(); wr(23'h555, 16'h0080); unlock(); wr(23'h555, 16'h0010);
    settle();
    chk_counts("R5", 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_mismatch();
    snap();
    wr(23'h555, 16'h00AA); wr(23'h2AA, 16'h0056);
    wr(23'h555, 16'h00A0); wr(23'h000100, 16'h1234);
    wr(23'h555, 16'h00AA); wr(23'h555, 16'h0055);
    wr(23'h555, 16'h00A0); wr(23'h000101, 16'h1235);
    settle();
    chk_counts("R6 bad cycles", 0, 0, 0, 0, 0, 0);
    unlock(); wr(23'h555, 16'h00A0); wr(23'h000102, 16'h4321);
    settle();
    chk_counts("R6 recovery", 1, 0, 0, 0, 0, 0);
    chk(last_data == 16'h4321, "R6 recovery data", last_data, 16'h4321);
  endtask

  task automatic t_abort();
    snap();
    unlock(); wr(23'h555, 16'h00F0);
    wr(23'h555, 16'h00A0); wr(23'h000200, 16'h0001);
    settle();
    chk_counts("R7 abort", 0, 0, 0, 0, 0, 1);
    snap();
    unlock(); wr(23'h555, 16'h00A0); wr(23'h000300, 16'h00F0);
    settle();
    chk_counts("R7 F0 as data", 1, 0, 0, 0, 0, 0);
    chk(last_data == 16'h00F0, "R7 data slot value", last_data, 16'h00F0);
  endtask

  task automatic t_prog_busy();
    snap();
    p_busy = 1'b1;
    unlock(); wr(23'h555, 16'h00A0); wr(23'h000400, 16'h9999);
    wr(23'h0, 16'h00B0); wr(23'h0, 16'h00F0); wr(23'h0, 16'h0030);
    unlock();
    p_busy = 1'b0;
    wr(23'h555, 16'h00A0); wr(23'h000401, 16'h8888);
    settle();
    chk_counts("R8", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_erase_busy();
    snap();
    e_busy = 1'b1;
    unlock(); wr(23'h555, 16'h00A0); wr(23'h000500, 16'h7777);
    wr(23'h0, 16'h00F0);
    wr(23'h012345, 16'h00B0);
    settle();
    e_busy = 1'b0;
    chk_counts("R9", 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_held();
    snap();
    e_held = 1'b1;
    unlock(); wr(23'h555, 16'h0080); unlock(); wr(23'h100000, 16'h0030);
    unlock(); wr(23'h555, 16'h0080); unlock(); wr(23'h555, 16'h0010);
    settle();
    chk_counts("R10 erase refused", 0, 0, 0, 0, 0, 0);
    snap();
    wr(23'h0, 16'h0030);
    unlock(); wr(23'h555, 16'h00A0); wr(23'h000600, 16'h6666);
    settle();
    chk_counts("R10 resume and program", 1, 0, 0, 0, 1, 0);
    e_held = 1'b0;
    snap();
    wr(23'h0, 16'h0030);
    settle();
    chk_counts("R10 resume outside hold", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_devrst();
    snap();
    unlock();
    @(negedge clk); dev_rst_n = 1'b0;
    repeat (4) @(negedge clk); dev_rst_n = 1'b1;
    wr(23'h555, 16'h00A0); wr(23'h000700, 16'h5555);
    settle();
    chk_counts("R11 partial lost", 0, 0, 0, 0, 0, 0);
    snap();
    unlock(); wr(23'h555, 16'h00A0); wr(23'h000701, 16'h4444);
    settle();
    chk_counts("R11 after release", 1, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; dev_rst_n = 1'b1; sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    addr = '0; data = '0; p_busy = 1'b0; e_busy = 1'b0; e_held = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_program();
    t_capture();
    t_sector();
    t_chip();
    t_mismatch();
    t_abort();
    t_prog_busy();
    t_erase_busy();
    t_held();
    t_devrst();
    chk(n_wide == 0, "R12 request wider than one clock", n_wide, 0);
    chk(n_multi == 0, "R12 several requests at once", n_multi, 0);
    finish_run();
  end
endmodule